// File: doc/BRIEF.md
# PIO Sector Transfer Engine

This block moves sector data between an internal one-sector word buffer and the 16-bit device data register while a programmed-I/O data command runs. For a data-in command it fetches each sector from a storage-side port into the buffer and then hands it to the host one word per data-register read. For a data-out command it collects one sector of host writes, then streams the sector out to storage. It keeps a per-block byte counter and a whole-command byte counter, drives the busy, data-request and seek-complete status bits, and decides when the per-block interrupt is raised.

Command decoding sits outside. A decoder pulses the start input with direction, sector count and base LBA. An identify request is served as a single data-in block. Its words come from a built-in table, not from storage. The interrupt policy differs by direction. Data-in raises an interrupt as each sector becomes ready. Data-out takes the first sector without one, raises one before each later sector, and raises one at command end.

Top module: `pio_sector_engine`

## Requirements
- R1: After reset, st_bsy, st_drq, st_dsc and irq are all 0 and the engine is idle.
- R2: On a data-in start (cmd_write=0, cmd_ident=0) the next cycle shows st_bsy=1, st_drq=0 and sto_rd_req=1 with sto_lba equal to cmd_lba. Once 256 words have been accepted through sto_rvalid, st_bsy=0 and st_drq=1, and dreg_rdata shows buffer word 0. Storage word n of a sector holds buffer bytes 2n (low byte) and 2n+1. st_bsy and st_drq are never both 1.
- R3: When a data-in sector becomes ready, irq rises unless irq_mask=1. Data reads are ignored until a status read (stat_rd). The status read clears irq and opens the transfer.
- R4: Each accepted 16-bit data read puts the next buffer word on dreg_rdata one cycle later. Both byte counters drop by 2 and never go below zero.
- R5: When a data-in block ends with command bytes left, the next cycle shows st_bsy=1 and st_drq=0, and a fetch starts at the previous LBA plus 1.
- R6: When the last word of a data-in command is read, the next cycle shows st_bsy=0 and st_drq=0, and no interrupt is raised.
- R7: A sector count of 0 means 256 sectors.
- R8: An identify start (cmd_ident=1) gives exactly one 512-byte data-in block whatever cmd_count holds. Word n is {8'hD1, n} and sto_rd_req stays 0.
- R9: On a data-out start (cmd_write=1) the next cycle shows st_drq=1 and st_bsy=0, and irq stays 0.
- R10: After 256 accepted data writes, the next cycle shows st_bsy=1, st_dsc=1 and st_drq=0. sto_wr_req then offers the words in write order on sto_wdata, with the sector's LBA on sto_lba, and advances on each cycle with sto_ready=1. Each later sector goes to the previous LBA plus 1.
- R11: Each data-out sector after the first raises irq unless irq_mask=1. Data writes before the status read are ignored.
- R12: When the last data-out sector has been stored, st_bsy=0 and st_drq=0, and irq rises unless irq_mask=1. A status read clears it.
- R13: A cmd_start while a command is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start pulse from the command decoder |
| cmd_write | input | 1 | 1 = data-out, 0 = data-in |
| cmd_ident | input | 1 | Serve the identification block |
| cmd_count | input | 8 | Sector count, 0 means 256 |
| cmd_lba | input | 28 | Base LBA |
| irq_mask | input | 1 | Interrupt disable |
| stat_rd | input | 1 | Status register read strobe |
| dreg_rd | input | 1 | Data register read strobe |
| dreg_wr | input | 1 | Data register write strobe |
| dreg_wdata | input | 16 | Data register write value |
| dreg_rdata | output | 16 | Data register read value |
| sto_rd_req | output | 1 | Sector fetch request |
| sto_wr_req | output | 1 | Sector store request |
| sto_lba | output | 28 | LBA of the sector being fetched or stored |
| sto_rvalid | input | 1 | Fetched word valid |
| sto_rdata | input | 16 | Fetched word |
| sto_ready | input | 1 | Store word accepted |
| sto_wdata | output | 16 | Word being stored |
| st_bsy | output | 1 | Busy status bit |
| st_drq | output | 1 | Data request status bit |
| st_dsc | output | 1 | Seek complete status bit |
| irq | output | 1 | Interrupt request |

## Verification
The status bits and irq change on the clock edge that takes a start, the last fill word, a status read or the last word of a block. The bench drives all strobes on the falling edge and reads the status one falling edge after that. dreg_rdata is due one edge after each accepted read, so the read loop compares each word on the falling edge before it asserts the next strobe. Store words are taken on the edge that sees sto_ready. The scoreboard therefore pops and compares on the falling edge where it raises sto_ready, while sto_wdata is stable until that edge.

// File: rtl/pio_xfer_pkg.sv
package pio_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_WAIT_IN,
    ST_XFER_IN,
    ST_XFER_OUT,
    ST_WAIT_OUT,
    ST_DRAIN
  } pio_state_e;

  // identification table word for index n
  function automatic logic [15:0] ident_word(input logic [7:0] n);
    return {8'hD1, n};
  endfunction

endpackage

// File: rtl/pio_sector_buf.sv
module pio_sector_buf #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pio_byte_cnt.sv
module pio_byte_cnt #(
  parameter int BLK_BYTES = 512,
  parameter int CMD_W     = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_load,
  input  logic [CMD_W-1:0] cmd_bytes,
  input  logic             blk_load,
  input  logic             dec,
  output logic             blk_last,
  output logic             cmd_last,
  output logic             cmd_zero
);
  localparam int BLK_W = $clog2(BLK_BYTES + 1);

  logic [BLK_W-1:0] blk_left;
  logic [CMD_W-1:0] cmd_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_left <= '0;
      cmd_left <= '0;
    end else begin
      if (cmd_load)  cmd_left <= cmd_bytes;
      else if (dec)  cmd_left <= cmd_left - CMD_W'(2);
      if (blk_load)  blk_left <= BLK_W'(BLK_BYTES);
      else if (dec)  blk_left <= blk_left - BLK_W'(2);
    end
  end

  assign blk_last = (blk_left == BLK_W'(2));
  assign cmd_last = (cmd_left == CMD_W'(2));
  assign cmd_zero = (cmd_left == '0);

  // R4: a word transfer never drives a counter below zero
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    dec |-> (blk_left >= BLK_W'(2)) && (cmd_left >= CMD_W'(2)));

  // R4: each word transfer removes two bytes from the command count
  p_step_two_r4: assert property (@(posedge clk) disable iff (rst)
    (dec && !cmd_load) |=> (cmd_left == $past(cmd_left) - CMD_W'(2)));
endmodule

// File: rtl/pio_sector_engine.sv
module pio_sector_engine
  import pio_xfer_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int LBA_W        = 28,
  parameter int CNT_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic             cmd_write,
  input  logic             cmd_ident,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic [LBA_W-1:0] cmd_lba,
  input  logic             irq_mask,
  input  logic             stat_rd,
  input  logic             dreg_rd,
  input  logic             dreg_wr,
  input  logic [15:0]      dreg_wdata,
  output logic [15:0]      dreg_rdata,
  output logic             sto_rd_req,
  output logic             sto_wr_req,
  output logic [LBA_W-1:0] sto_lba,
  input  logic             sto_rvalid,
  input  logic [15:0]      sto_rdata,
  input  logic             sto_ready,
  output logic [15:0]      sto_wdata,
  output logic             st_bsy,
  output logic             st_drq,
  output logic             st_dsc,
  output logic             irq
);
  localparam int WORDS    = SECTOR_BYTES / 2;
  localparam int AW       = $clog2(WORDS);
  localparam int MAX_SECT = 2 ** CNT_W;
  localparam int CMD_W    = $clog2(MAX_SECT * SECTOR_BYTES + 1);
  localparam logic [AW-1:0] LAST_W = AW'(WORDS - 1);

  pio_state_e       state;
  logic             ident_q;
  logic [LBA_W-1:0] lba_q;
  logic [AW-1:0]    fill_idx, w_idx, raddr, waddr;
  logic [15:0]      ram_q, ram_wdata;
  logic             ram_we;
  logic             start_ok, rd_acc, wr_acc, dr_acc, fill_acc, advance;
  logic             fill_done, drain_done, blk_load;
  logic             blk_last, cmd_last, cmd_zero;
  logic [CMD_W-1:0] sect_n, start_bytes;

  assign start_ok  = cmd_start && (state == ST_IDLE);
  assign rd_acc    = (state == ST_XFER_IN)  && dreg_rd;
  assign wr_acc    = (state == ST_XFER_OUT) && dreg_wr;
  assign dr_acc    = (state == ST_DRAIN)    && sto_ready;
  assign fill_acc  = (state == ST_FILL) && (ident_q || sto_rvalid);
  assign advance   = rd_acc || wr_acc || dr_acc;
  assign fill_done = fill_acc && (fill_idx == LAST_W);
  assign drain_done = dr_acc && (w_idx == LAST_W);
  assign blk_load  = fill_done || (drain_done && !cmd_zero) ||
                     (start_ok && cmd_write && !cmd_ident);

  assign sect_n      = (cmd_count == '0) ? CMD_W'(MAX_SECT) : CMD_W'(cmd_count);
  assign start_bytes = cmd_ident ? CMD_W'(SECTOR_BYTES)
                                 : sect_n * CMD_W'(SECTOR_BYTES);

  // read port always shows the word at the transfer pointer
  assign raddr     = advance ? (w_idx + AW'(1)) : w_idx;
  assign ram_we    = fill_acc || wr_acc;
  assign waddr     = (state == ST_FILL) ? fill_idx : w_idx;
  assign ram_wdata = (state != ST_FILL) ? dreg_wdata :
                     ident_q ? ident_word(8'(fill_idx)) : sto_rdata;

  pio_sector_buf #(.AW(AW), .DW(16)) u_buf (
    .clk(clk), .we(ram_we), .waddr(waddr), .wdata(ram_wdata),
    .raddr(raddr), .rdata(ram_q)
  );

  pio_byte_cnt #(.BLK_BYTES(SECTOR_BYTES), .CMD_W(CMD_W)) u_cnt (
    .clk(clk), .rst(rst), .cmd_load(start_ok), .cmd_bytes(start_bytes),
    .blk_load(blk_load), .dec(rd_acc || wr_acc),
    .blk_last(blk_last), .cmd_last(cmd_last), .cmd_zero(cmd_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ident_q  <= 1'b0;
      lba_q    <= '0;
      fill_idx <= '0;
      w_idx    <= '0;
      st_bsy   <= 1'b0;
      st_drq   <= 1'b0;
      st_dsc   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (stat_rd) irq <= 1'b0;
      if (advance) w_idx <= w_idx + AW'(1);
      unique case (state)
        ST_IDLE: if (cmd_start) begin
          irq      <= 1'b0;
          ident_q  <= cmd_ident;
          lba_q    <= cmd_lba;
          w_idx    <= '0;
          fill_idx <= '0;
          if (cmd_write && !cmd_ident) begin
            state  <= ST_XFER_OUT;
            st_drq <= 1'b1;
          end else begin
            state  <= ST_FILL;
            st_bsy <= 1'b1;
          end
        end
        ST_FILL: if (fill_acc) begin
          fill_idx <= fill_idx + AW'(1);
          if (fill_done) begin
            st_bsy <= 1'b0;
            st_drq <= 1'b1;
            w_idx  <= '0;
            if (!ident_q) lba_q <= lba_q + LBA_W'(1);
            if (!irq_mask) begin
              irq   <= 1'b1;
              state <= ST_WAIT_IN;
            end else begin
              state <= ST_XFER_IN;
            end
          end
        end
        ST_WAIT_IN:  if (stat_rd) state <= ST_XFER_IN;
        ST_XFER_IN: if (dreg_rd && blk_last) begin
          st_drq <= 1'b0;
          if (cmd_last) begin
            st_bsy <= 1'b0;
            state  <= ST_IDLE;
          end else begin
            st_bsy   <= 1'b1;
            fill_idx <= '0;
            state    <= ST_FILL;
          end
        end
        ST_XFER_OUT: if (dreg_wr && blk_last) begin
          st_drq <= 1'b0;
          st_bsy <= 1'b1;
          st_dsc <= 1'b1;
          state  <= ST_DRAIN;
        end
        ST_WAIT_OUT: if (stat_rd) state <= ST_XFER_OUT;
        ST_DRAIN: if (drain_done) begin
          lba_q  <= lba_q + LBA_W'(1);
          st_bsy <= 1'b0;
          if (cmd_zero) begin
            irq   <= !irq_mask;
            state <= ST_IDLE;
          end else begin
            st_drq <= 1'b1;
            if (!irq_mask) begin
              irq   <= 1'b1;
              state <= ST_WAIT_OUT;
            end else begin
              state <= ST_XFER_OUT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dreg_rdata = ram_q;
  assign sto_wdata  = ram_q;
  assign sto_lba    = lba_q;
  assign sto_rd_req = (state == ST_FILL) && !ident_q;
  assign sto_wr_req = (state == ST_DRAIN);

  // R2: busy and data request are never reported together
  p_bsy_drq_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(st_bsy && st_drq));

  // R3: while waiting for the status read the data register holds still
  p_wait_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_IN && !stat_rd) |=> (state == ST_WAIT_IN) && $stable(dreg_rdata));

  // R5: a fetched sector moves the LBA on by one
  p_lba_step_r5: assert property (@(posedge clk) disable iff (rst)
    (fill_done && !ident_q) |=> (sto_lba == $past(sto_lba) + LBA_W'(1)));

  // R6: last data-in word ends the command quietly
  p_in_done_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && blk_last && cmd_last) |=> (!st_bsy && !st_drq && !irq));

  // R9: data-out opens with a data request and no interrupt
  p_first_out_r9: assert property (@(posedge clk) disable iff (rst)
    (start_ok && cmd_write && !cmd_ident) |=> (st_drq && !st_bsy && !irq));

  // R10: a full written block commits with busy and seek complete
  p_commit_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && blk_last) |=> (st_bsy && st_dsc && sto_wr_req && !st_drq));

  // R13: a start during a transfer changes nothing
  p_start_ignored_r13: assert property (@(posedge clk) disable iff (rst)
    (state == ST_XFER_OUT && cmd_start && !dreg_wr) |=> (state == ST_XFER_OUT));
endmodule

// File: tb/tb_pio_sector_engine.sv
`timescale 1ns/1ps
module tb_pio_sector_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 0, cmd_write = 0, cmd_ident = 0;
  logic [7:0]  cmd_count = 0;
  logic [27:0] cmd_lba = 0;
  logic        irq_mask = 0, stat_rd = 0, dreg_rd = 0, dreg_wr = 0;
  logic [15:0] dreg_wdata = 0;
  logic [15:0] dreg_rdata;
  logic        sto_rd_req, sto_wr_req;
  logic [27:0] sto_lba;
  logic        sto_rvalid = 0;
  logic [15:0] sto_rdata = 0;
  logic        sto_ready = 0;
  logic [15:0] sto_wdata;
  logic        st_bsy, st_drq, st_dsc, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [43:0] exp_q[$];
  logic [7:0]  rcnt = 0;

  always #4 clk = ~clk;

  pio_sector_engine dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_write(cmd_write),
    .cmd_ident(cmd_ident), .cmd_count(cmd_count), .cmd_lba(cmd_lba),
    .irq_mask(irq_mask), .stat_rd(stat_rd), .dreg_rd(dreg_rd),
    .dreg_wr(dreg_wr), .dreg_wdata(dreg_wdata), .dreg_rdata(dreg_rdata),
    .sto_rd_req(sto_rd_req), .sto_wr_req(sto_wr_req), .sto_lba(sto_lba),
    .sto_rvalid(sto_rvalid), .sto_rdata(sto_rdata), .sto_ready(sto_ready),
    .sto_wdata(sto_wdata), .st_bsy(st_bsy), .st_drq(st_drq),
    .st_dsc(st_dsc), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] disk_word(input logic [27:0] lba, input int k);
    return {lba[7:0], 8'(k)};
  endfunction

  function automatic logic [15:0] host_word(input int s, input int k);
    return 16'(k * 3 + s * 16'h1111 + 16'h0400);
  endfunction

  // storage model and store-side scoreboard monitor
  always @(negedge clk) begin
    if (sto_rd_req) begin
      sto_rvalid = 1'b1;
      sto_rdata  = disk_word(sto_lba, int'(rcnt));
      rcnt       = rcnt + 8'd1;
    end else begin
      sto_rvalid = 1'b0;
      rcnt       = 8'd0;
    end
    sto_ready = ~sto_ready;
    if (sto_ready && sto_wr_req) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected store", {36'd0, sto_wdata}, 64'd0);
      end else begin
        logic [43:0] e;
        e = exp_q.pop_front();
        chk({sto_lba, sto_wdata} == e, "R10 stored word", {20'd0, sto_lba, sto_wdata},
            {20'd0, e});
      end
    end
  end

  task automatic start_cmd(input bit wr, input bit id, input logic [7:0] cnt,
                           input logic [27:0] lba);
    cmd_write = wr; cmd_ident = id; cmd_count = cnt; cmd_lba = lba;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic pulse_stat();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic wait_drq();
    while (!st_drq) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (st_bsy) @(negedge clk);
  endtask

  task automatic read_sector(input bit id, input logic [27:0] lba);
    for (int k = 0; k < 256; k++) begin
      logic [15:0] e;
      e = id ? {8'hD1, 8'(k)} : disk_word(lba, k);
      chk(dreg_rdata == e, id ? "R8 ident word" : "R4 data word", {48'd0, dreg_rdata},
          {48'd0, e});
      dreg_rd = 1'b1;
      @(negedge clk);
    end
    dreg_rd = 1'b0;
  endtask

  task automatic write_sector(input int s, input logic [27:0] lba);
    for (int k = 0; k < 256; k++) begin
      dreg_wdata = host_word(s, k);
      exp_q.push_back({lba, host_word(s, k)});
      dreg_wr = 1'b1;
      @(negedge clk);
    end
    dreg_wr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 64'd0, 64'd1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset values
    chk({st_bsy, st_drq, st_dsc, irq} == 4'b0, "R1 reset status",
        {60'd0, st_bsy, st_drq, st_dsc, irq}, 64'd0);

    // data-in, two sectors, interrupts enabled
    irq_mask = 1'b0;
    start_cmd(1'b0, 1'b0, 8'd2, 28'h0000123);
    chk(st_bsy && !st_drq && sto_rd_req, "R2 fetch start", {61'd0, st_bsy, st_drq, sto_rd_req},
        64'b101);
    chk(sto_lba == 28'h0000123, "R2 fetch lba", {36'd0, sto_lba}, 64'h123);
    // R13: start pulse during the fetch
    start_cmd(1'b1, 1'b0, 8'd9, 28'h0000777);
    chk(sto_lba == 28'h0000123 && sto_rd_req, "R13 start ignored", {36'd0, sto_lba}, 64'h123);
    wait_drq();
    chk(!st_bsy && dreg_rdata == disk_word(28'h123, 0), "R2 first word", {48'd0, dreg_rdata},
        {48'd0, disk_word(28'h123, 0)});
    chk(irq == 1'b1, "R3 sector irq", {63'd0, irq}, 64'd1);
    dreg_rd = 1'b1;
    @(negedge clk);
    dreg_rd = 1'b0;
    chk(dreg_rdata == disk_word(28'h123, 0) && st_drq, "R3 read before status ignored",
        {48'd0, dreg_rdata}, {48'd0, disk_word(28'h123, 0)});
    pulse_stat();
    chk(irq == 1'b0, "R3 status read clears irq", {63'd0, irq}, 64'd0);
    read_sector(1'b0, 28'h0000123);
    chk(st_bsy && !st_drq && sto_lba == 28'h0000124, "R5 next fetch",
        {34'd0, st_bsy, st_drq, sto_lba}, {34'd0, 2'b10, 28'h0000124});
    wait_drq();
    chk(irq == 1'b1, "R3 second sector irq", {63'd0, irq}, 64'd1);
    pulse_stat();
    read_sector(1'b0, 28'h0000124);
    chk({st_bsy, st_drq, irq} == 3'b000, "R6 data-in end", {61'd0, st_bsy, st_drq, irq}, 64'd0);

    // identify, interrupts masked
    irq_mask = 1'b1;
    start_cmd(1'b0, 1'b1, 8'd5, 28'h0000055);
    chk(st_bsy && !sto_rd_req, "R8 no storage fetch", {62'd0, st_bsy, sto_rd_req}, 64'b10);
    wait_drq();
    chk(irq == 1'b0, "R3 masked irq", {63'd0, irq}, 64'd0);
    read_sector(1'b1, 28'h0);
    chk({st_bsy, st_drq} == 2'b00, "R8 single block", {62'd0, st_bsy, st_drq}, 64'd0);

    // data-out, two sectors, interrupts enabled
    irq_mask = 1'b0;
    start_cmd(1'b1, 1'b0, 8'd2, 28'hABCDEF0);
    chk({st_drq, st_bsy, irq} == 3'b100, "R9 first sector", {61'd0, st_drq, st_bsy, irq},
        64'b100);
    write_sector(0, 28'hABCDEF0);
    chk({st_bsy, st_dsc, st_drq, sto_wr_req} == 4'b1101, "R10 commit",
        {60'd0, st_bsy, st_dsc, st_drq, sto_wr_req}, 64'b1101);
    wait_drq();
    chk(irq == 1'b1 && !st_bsy, "R11 later sector irq", {62'd0, irq, st_bsy}, 64'b10);
    dreg_wdata = 16'hDEAD;
    dreg_wr = 1'b1;
    @(negedge clk);
    dreg_wr = 1'b0;
    pulse_stat();
    chk(irq == 1'b0, "R11 status read clears irq", {63'd0, irq}, 64'd0);
    write_sector(1, 28'hABCDEF1);
    wait_idle();
    chk({st_drq, irq} == 2'b01, "R12 completion irq", {62'd0, st_drq, irq}, 64'b01);
    pulse_stat();
    chk(irq == 1'b0, "R12 status read clears irq", {63'd0, irq}, 64'd0);
    chk(exp_q.size() == 0, "R10 all words stored", 64'(exp_q.size()), 64'd0);

    // data-out, one sector, masked
    irq_mask = 1'b1;
    start_cmd(1'b1, 1'b0, 8'd1, 28'h0000042);
    write_sector(7, 28'h0000042);
    wait_idle();
    chk({st_drq, irq} == 2'b00, "R12 masked completion", {62'd0, st_drq, irq}, 64'd0);
    chk(exp_q.size() == 0, "R10 single sector stored", 64'(exp_q.size()), 64'd0);

    // R7: count zero runs 256 sectors
    start_cmd(1'b0, 1'b0, 8'd0, 28'h0000010);
    for (int s = 0; s < 256; s++) begin
      wait_drq();
      read_sector(1'b0, 28'h0000010 + 28'(s));
    end
    chk({st_bsy, st_drq} == 2'b00, "R7 256 sectors then idle", {62'd0, st_bsy, st_drq}, 64'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule